// File: doc/BRIEF.md
# Contactless Type B Response Framer

This block turns a short frame of bytes into the baseband symbol stream that a proximity card returns to a reader. The bytes already carry their check code. One symbol is produced per clock, and every elementary time unit (ETU) lasts four clocks. A frame has the following parts, in this order:

- a long run of ones that lets the reader lock its phase;
- a start-of-frame mark;
- one ten-bit character per byte;
- an end-of-frame mark.

A separate stage, outside this block, applies subcarrier modulation to the stream.

A frame starts with a request that carries a byte count. The block then pulls the bytes one at a time over a valid/ready handshake, exactly when each byte is needed. If the source is late, the line rests at logic 1 in whole ETUs until the byte arrives. The block has no buffer beyond the character being sent.

Top module: `rsp_framer`

## Requirements
- R1: Out of reset and between frames, `sym_out` is 1, `frame_active` is 0, `req_ready` is 1 and `byte_ready` is 0.
- R2: Every ETU of a frame is emitted as four identical consecutive samples.
- R3: A frame opens with 20 ETUs of logic 1.
- R4: The start-of-frame mark follows: 10 ETUs of 0, then 2 ETUs of 1.
- R5: Each byte is sent as a start bit of 0, then its eight data bits with bit 0 first, then a stop bit of 1.
- R6: When each byte is offered as soon as it is requested, consecutive characters follow each other with no extra time beyond the single stop bit.
- R7: The frame closes with 10 ETUs of 0 and then 2 ETUs of 1, and the last sample of a frame is 1.
- R8: `frame_active` is 1 for exactly the samples from the first preamble sample to the last end-mark sample, that is 4*(44 + 10*N + G) samples for N bytes and G waiting ETUs.
- R9: A request whose length is 0 produces no frame, and the block stays ready for a new request.
- R10: `byte_ready` is raised only in the last sample of the final start-mark ETU, of a stop bit with bytes still owed, or of a waiting ETU. Exactly N bytes are taken per frame.
- R11: If no byte is valid when one is requested, the line holds 1 for whole ETUs until the byte is taken, and the character then follows at once.
- R12: A request is accepted only while the block is idle. Requests raised during a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one output symbol per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request strobe |
| req_len | input | LEN_W | Number of bytes in the requested frame |
| req_ready | output | 1 | High when a request can be accepted (idle) |
| byte_valid | input | 1 | Next byte is present on `byte_data` |
| byte_data | input | DATA_W | Byte to serialize, bit 0 sent first |
| byte_ready | output | 1 | Block takes a byte at this clock if `byte_valid` |
| sym_out | output | 1 | Oversampled baseband symbol, registered |
| frame_active | output | 1 | High for every sample of a frame, registered |

## Verification
Two events can coincide at a stop-bit boundary. The same clock that ends the final sample of a stop bit can also take the next byte, which reloads the character register and restarts the bit count. Random frames hit this case, and so do directed back-to-back frames. Starvation tests withhold a chosen byte for a random number of request pulses, so that a take collides instead with the end of a waiting ETU. Each captured stream is compared sample by sample with a stream that the bench builds from the byte list and the number of waiting ETUs. The exact length of the active window is also checked.

// File: rtl/rsp_framer_pkg.sv
`timescale 1ns/1ps
package rsp_framer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SOFL,
    ST_SOFH,
    ST_CHR,
    ST_GAP,
    ST_EOFL,
    ST_EOFH
  } frm_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/etu_pacer.sv
`timescale 1ns/1ps
module etu_pacer #(
  parameter int OVS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic etu_last
);
  generate
    if (OVS == 1) begin : g_single
      assign etu_last = run;
    end else begin : g_multi
      localparam int PH_W = $clog2(OVS);
      logic [PH_W-1:0] ph;
      always_ff @(posedge clk) begin
        if (rst || !run)                 ph <= '0;
        else if (ph == PH_W'(OVS - 1))   ph <= '0;
        else                             ph <= ph + 1'b1;
      end
      assign etu_last = run && (ph == PH_W'(OVS - 1));
    end
  endgenerate
endmodule

// File: rtl/char_shifter.sv
`timescale 1ns/1ps
module char_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              shift,
  output logic              bit_o
);
  localparam int SR_W = DATA_W + 2;
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '1;
    else if (load)  sr <= {1'b1, din, 1'b0};
    else if (shift) sr <= {1'b1, sr[SR_W-1:1]};
  end

  assign bit_o = sr[0];
endmodule

// File: rtl/frame_seq.sv
`timescale 1ns/1ps
module frame_seq
  import rsp_framer_pkg::*;
#(
  parameter int PRE_ETU = 20,
  parameter int SOF_LO  = 10,
  parameter int SOF_HI  = 2,
  parameter int EOF_LO  = 10,
  parameter int EOF_HI  = 2,
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             etu_last,
  input  logic             byte_valid,
  output frm_state_e       state,
  output logic             req_ready,
  output logic             byte_ready,
  output logic             take,
  output logic             shift
);
  localparam int CHAR_ETU = DATA_W + 2;
  localparam int CNT_MAX  = max_of(max_of(PRE_ETU, CHAR_ETU),
                                   max_of(max_of(SOF_LO, SOF_HI), max_of(EOF_LO, EOF_HI)));
  localparam int CNT_W    = $clog2(CNT_MAX) + 1;

  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] left;
  logic             char_end;

  always_comb begin
    req_ready  = (state == ST_IDLE);
    char_end   = (state == ST_CHR) && (cnt == CNT_W'(CHAR_ETU - 1));
    byte_ready = etu_last &&
                 (((state == ST_SOFH) && (cnt == CNT_W'(SOF_HI - 1))) ||
                  (char_end && (left != '0)) ||
                  (state == ST_GAP));
    take       = byte_ready && byte_valid;
    shift      = etu_last && (state == ST_CHR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      left  <= '0;
    end else if (state == ST_IDLE) begin
      if (req_valid && (req_len != '0)) begin
        state <= ST_PRE;
        cnt   <= '0;
        left  <= req_len;
      end
    end else begin
      if (take) left <= left - 1'b1;
      if (etu_last) begin
        case (state)
          ST_PRE: begin
            if (cnt == CNT_W'(PRE_ETU - 1)) begin
              state <= ST_SOFL;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_SOFL: begin
            if (cnt == CNT_W'(SOF_LO - 1)) begin
              state <= ST_SOFH;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_SOFH: begin
            if (cnt == CNT_W'(SOF_HI - 1)) begin
              state <= take ? ST_CHR : ST_GAP;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_CHR: begin
            if (char_end) begin
              cnt <= '0;
              if (left == '0) state <= ST_EOFL;
              else            state <= take ? ST_CHR : ST_GAP;
            end else cnt <= cnt + 1'b1;
          end
          ST_GAP: begin
            if (take) begin
              state <= ST_CHR;
              cnt   <= '0;
            end
          end
          ST_EOFL: begin
            if (cnt == CNT_W'(EOF_LO - 1)) begin
              state <= ST_EOFH;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_EOFH: begin
            if (cnt == CNT_W'(EOF_HI - 1)) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: begin
            state <= ST_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rsp_framer.sv
`timescale 1ns/1ps
module rsp_framer
  import rsp_framer_pkg::*;
#(
  parameter int OVS     = 4,
  parameter int PRE_ETU = 20,
  parameter int SOF_LO  = 10,
  parameter int SOF_HI  = 2,
  parameter int EOF_LO  = 10,
  parameter int EOF_HI  = 2,
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              sym_out,
  output logic              frame_active
);
  frm_state_e state;
  logic       etu_last, take, shift, char_bit, run, sym_nxt;

  assign run = (state != ST_IDLE);

  etu_pacer #(.OVS(OVS)) u_pacer (
    .clk(clk), .rst(rst), .run(run), .etu_last(etu_last)
  );

  frame_seq #(
    .PRE_ETU(PRE_ETU), .SOF_LO(SOF_LO), .SOF_HI(SOF_HI),
    .EOF_LO(EOF_LO), .EOF_HI(EOF_HI), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
    .etu_last(etu_last), .byte_valid(byte_valid), .state(state),
    .req_ready(req_ready), .byte_ready(byte_ready), .take(take), .shift(shift)
  );

  char_shifter #(.DATA_W(DATA_W)) u_chr (
    .clk(clk), .rst(rst), .load(take), .din(byte_data),
    .shift(shift), .bit_o(char_bit)
  );

  always_comb begin
    case (state)
      ST_SOFL, ST_EOFL: sym_nxt = 1'b0;
      ST_CHR:           sym_nxt = char_bit;
      default:          sym_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_out      <= 1'b1;
      frame_active <= 1'b0;
    end else begin
      sym_out      <= sym_nxt;
      frame_active <= run;
    end
  end
endmodule

// File: rtl/rsp_framer_chk.sv
`timescale 1ns/1ps
module rsp_framer_chk #(
  parameter int OVS   = 4,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [LEN_W-1:0] req_len,
  input logic             req_ready,
  input logic             byte_ready,
  input logic             sym_out,
  input logic             frame_active
);
  localparam int PH_W = (OVS > 1) ? $clog2(OVS) : 1;
  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !frame_active)          ph <= '0;
    else if (ph == PH_W'(OVS - 1))     ph <= '0;
    else                               ph <= ph + 1'b1;
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !frame_active |-> sym_out);                                          // R1
  AST_ETU_HOLD: assert property (@(posedge clk) disable iff (rst)
    (frame_active && ph != '0) |-> (sym_out == $past(sym_out)));         // R2
  AST_LAST_SAMPLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_active) |-> $past(sym_out));                             // R7
  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == '0) |=> req_ready);            // R9
  AST_PULL_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    byte_ready |-> (frame_active && !req_ready));                        // R10
  AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_active) |-> $past(req_valid && req_ready, 2));           // R12
endmodule

bind rsp_framer rsp_framer_chk #(.OVS(OVS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
  .req_ready(req_ready), .byte_ready(byte_ready), .sym_out(sym_out),
  .frame_active(frame_active)
);

// File: tb/test_rsp_framer.sv
`timescale 1ns/1ps
module test_rsp_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_len = '0;
  logic       req_ready;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       byte_ready;
  logic       sym_out;
  logic       frame_active;

  int checks = 0;
  int errors = 0;

  logic [7:0] tx [16];
  int  tx_idx = 0;
  int  skip_k = -1;
  int  skip_left = 0;
  bit  armed = 0;
  bit  seen = 0;
  bit  done = 0;
  bit  cap_q[$];
  bit  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  rsp_framer i_rsp_framer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
    .req_ready(req_ready), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .sym_out(sym_out), .frame_active(frame_active)
  );

  // byte source and capture, both away from the active edge
  always @(negedge clk) begin
    if (byte_ready) begin
      if (tx_idx == skip_k && skip_left > 0) begin
        byte_valid = 1'b0;
        skip_left--;
      end else begin
        byte_valid = 1'b1;
        byte_data  = tx[tx_idx];
        tx_idx++;
      end
    end else begin
      byte_valid = 1'b0;
    end
    if (armed) begin
      if (frame_active) begin
        cap_q.push_back(sym_out);
        seen = 1;
      end else if (seen) begin
        done = 1;
      end
    end
  end

  task automatic push_etu(bit b, string t);
    repeat (4) begin
      exp_q.push_back(b);
      tag_q.push_back(t);
    end
  endtask

  task automatic build_exp(int n, int gk, int gn);
    exp_q.delete();
    tag_q.delete();
    repeat (20) push_etu(1'b1, "R3");
    repeat (10) push_etu(1'b0, "R4");
    repeat (2)  push_etu(1'b1, "R4");
    for (int k = 0; k < n; k++) begin
      if (k == gk) repeat (gn) push_etu(1'b1, "R11");
      push_etu(1'b0, "R5");
      for (int j = 0; j < 8; j++) push_etu(tx[k][j], "R5");
      push_etu(1'b1, "R6");
    end
    repeat (10) push_etu(1'b0, "R7");
    repeat (2)  push_etu(1'b1, "R7");
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(int n, int gk, int gn, bit poke);
    int mism;
    bit grp_ok;
    tx_idx = 0; skip_k = gk; skip_left = gn;
    cap_q.delete(); seen = 0; done = 0; armed = 1;
    build_exp(n, gk, gn);
    @(negedge clk); req_len = 8'(n); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    if (poke) begin
      repeat (8) @(negedge clk);
      req_len = 8'd3; req_valid = 1'b1;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    armed = 0;
    chk(cap_q.size() == exp_q.size(), "R8", "active window length", cap_q.size(), exp_q.size());
    mism = -1;
    for (int i = 0; i < cap_q.size() && i < exp_q.size(); i++)
      if (mism < 0 && cap_q[i] != exp_q[i]) mism = i;
    if (mism >= 0)
      chk(1'b0, tag_q[mism], $sformatf("sample %0d of frame", mism), cap_q[mism], exp_q[mism]);
    else
      chk(1'b1, "R5", "stream", 0, 0);
    grp_ok = (cap_q.size() % 4) == 0;
    for (int i = 0; i + 3 < cap_q.size(); i += 4)
      if (cap_q[i] != cap_q[i+1] || cap_q[i] != cap_q[i+2] || cap_q[i] != cap_q[i+3]) grp_ok = 0;
    chk(grp_ok, "R2", "ETU groups of four", grp_ok, 1);
    chk(tx_idx == n, "R10", "bytes taken", tx_idx, n);
    chk(sym_out && !frame_active && req_ready && !byte_ready, "R1", "idle after frame",
        {sym_out, frame_active, req_ready, byte_ready}, 4'b1010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit idle_ok;
    void'($urandom(32'h5EED_B0B0));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sym_out && !frame_active && req_ready && !byte_ready, "R1", "reset state",
        {sym_out, frame_active, req_ready, byte_ready}, 4'b1010);

    // R9: zero-length request
    @(negedge clk); req_len = 8'd0; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    idle_ok = 1;
    repeat (40) begin
      @(negedge clk);
      if (frame_active || !sym_out) idle_ok = 0;
    end
    chk(idle_ok && req_ready, "R9", "zero length stays idle", frame_active, 0);

    // R5: single byte with alternating bits
    tx[0] = 8'hA5;
    run_frame(1, -1, 0, 0);
    // R6: back-to-back characters
    tx[0] = 8'h3C; tx[1] = 8'h00; tx[2] = 8'hFF;
    run_frame(3, -1, 0, 0);
    // R11: first byte late by two ETUs
    tx[0] = 8'h81; tx[1] = 8'h7E;
    run_frame(2, 0, 2, 0);
    // R11: middle byte late by one ETU
    tx[0] = 8'h12; tx[1] = 8'h34; tx[2] = 8'h56;
    run_frame(3, 1, 1, 0);
    // R12: requests raised during a frame are ignored
    tx[0] = 8'hC3; tx[1] = 8'h5A;
    run_frame(2, -1, 0, 1);
    idle_ok = 1;
    repeat (50) begin
      @(negedge clk);
      if (frame_active) idle_ok = 0;
    end
    chk(idle_ok, "R12", "no frame from busy request", !idle_ok, 0);

    // random frames
    for (int f = 0; f < 10; f++) begin
      int n, gk, gn;
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) tx[k] = 8'($urandom);
      if ($urandom % 3 == 0) begin
        gk = int'($urandom % n);
        gn = 1 + int'($urandom % 3);
      end else begin
        gk = -1;
        gn = 0;
      end
      run_frame(n, gk, gn, 0);
      repeat (int'($urandom % 5)) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule